// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two 8-bit bidirectional ports, called A and B, inside a chip. Each port has its own capture register. The register on a side loads the data present on that side's input when its strobe rises. An active-low output enable and a direction input select which port drives: none, B, or A. For each direction, a select input decides what the driving port shows. It either passes the other port's live input straight through, or it shows the stored register of the other side.

Each pin is split into an input vector, an output vector and an output-enable bit, so the block can be used behind pad logic or on an internal bus. Both strobes are sampled in the single system clock domain. A capture happens on the clock edge where a strobe is high and was low on the edge before. Capture keeps running whether or not a port is driving, so a port can be sampled while both sides are isolated. Stored mode forwards a value in the same step that captures it: the clock edge that loads the register also changes the driven port.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On a clock edge where `a_stb` is 1 and was 0 at the previous edge, the A register loads `a_in`. The new value is visible from that edge on.
- R2: On a clock edge where `b_stb` is 1 and was 0 at the previous edge, the B register loads `b_in` in the same way.
- R3: Capture on both sides works for every setting of `oe_n` and `dir`, including isolation.
- R4: When `oe_n` is 1, `a_oe` and `b_oe` are both 0. Any output whose enable is 0 reads all zeros.
- R5: When `oe_n` is 0 and `dir` is 1, `b_oe` is 1 and `a_oe` is 0.
- R6: When `oe_n` is 0 and `dir` is 0, `a_oe` is 1 and `b_oe` is 0.
- R7: While B drives and `sel_a2b` is 0, `b_out` equals `a_in` combinationally, with no clock delay.
- R8: While B drives and `sel_a2b` is 1, `b_out` equals the A register.
- R9: While A drives and `sel_b2a` is 0, `a_out` equals `b_in` combinationally.
- R10: While A drives and `sel_b2a` is 1, `a_out` equals the B register.
- R11: In stored mode, the edge that captures on the source side also updates the driven port. Before that edge, the driven port still shows the old stored value.
- R12: The select input of the direction that is not driving has no effect on either output.
- R13: When `rst_n` goes low, both registers clear to zero at once, without waiting for a clock edge. Stored-mode output is then zero.
- R14: A strobe held high captures only once. Later changes on that port's input leave the register unchanged until the strobe falls and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_n | input | 1 | Active-low output enable (1 = isolation) |
| dir | input | 1 | 1 = B drives, 0 = A drives |
| sel_a2b | input | 1 | B-side source: 0 live A input, 1 A register |
| sel_b2a | input | 1 | A-side source: 0 live B input, 1 B register |
| a_stb | input | 1 | A capture strobe, acts on its rising edge |
| b_stb | input | 1 | B capture strobe, acts on its rising edge |
| a_in | input | WIDTH | Value seen on port A |
| a_out | output | WIDTH | Value driven onto port A |
| a_oe | output | 1 | Port A drive enable |
| b_in | input | WIDTH | Value seen on port B |
| b_out | output | WIDTH | Value driven onto port B |
| b_oe | output | 1 | Port B drive enable |

## Verification
The live paths are exercised with all-zeros, all-ones, alternating and edge-bit patterns. Using these patterns separates a straight connection from a swapped, stuck or registered one. Stored mode is read back only after captures made in isolation with different values on each side, so a crossed register or a capture gated by the enable shows up as a wrong value. The capture-and-forward sequence samples the driven port just before and just after the capturing edge, to pin down the one-edge latency. A strobe held high while its input keeps changing, toggles of the unused select, and a reset in the middle of the run cover the remaining corner cases.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Which side of the transceiver is currently driving.
  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_TO_B = 2'd1,
    DRV_TO_A = 2'd2
  } drive_e;

  // Drive decode: isolation wins, then direction picks the side.
  function automatic drive_e pick_drive(input logic oe_n, input logic dir);
    if (oe_n) return DRV_NONE;
    return dir ? DRV_TO_B : DRV_TO_A;
  endfunction

endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] held,
  output logic             fire
);

  logic strobe_q;

  // Capture event: strobe high now, low at the previous edge.
  assign fire = strobe & ~strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      held     <= '0;
    end else begin
      strobe_q <= strobe;
      if (fire) held <= din;
    end
  end

  // R1 on the A instance, R2 on the B instance
  assert_capture_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> held == $past(din));

  // Without a fresh strobe edge the register keeps its value.
  assert_capture_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(held));

  // A strobe held high fires only once.
  assert_single_fire_R14: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);

endmodule

// File: rtl/xcvr_route.sv
module xcvr_route
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  drive_e           mode,
  input  logic             sel_a2b,
  input  logic             sel_b2a,
  input  logic [WIDTH-1:0] a_live,
  input  logic [WIDTH-1:0] b_live,
  input  logic [WIDTH-1:0] a_held,
  input  logic [WIDTH-1:0] b_held,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);

  // Output word: zero when not driving, else live or stored source.
  function automatic logic [WIDTH-1:0] gate_word(input logic en, input logic use_held,
                                                 input logic [WIDTH-1:0] live,
                                                 input logic [WIDTH-1:0] stored);
    if (!en) return '0;
    return use_held ? stored : live;
  endfunction

  assign b_oe  = (mode == DRV_TO_B);
  assign a_oe  = (mode == DRV_TO_A);
  assign b_out = gate_word(b_oe, sel_a2b, a_live, a_held);
  assign a_out = gate_word(a_oe, sel_b2a, b_live, b_held);

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_a2b,
  input  logic             sel_b2a,
  input  logic             a_stb,
  input  logic             b_stb,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);

  drive_e           mode;
  logic [WIDTH-1:0] a_held, b_held;
  logic             a_fire, b_fire;

  assign mode = pick_drive(oe_n, dir);

  xcvr_capture #(.WIDTH(WIDTH)) u_cap_a (
    .clk(clk), .rst_n(rst_n), .strobe(a_stb), .din(a_in),
    .held(a_held), .fire(a_fire)
  );

  xcvr_capture #(.WIDTH(WIDTH)) u_cap_b (
    .clk(clk), .rst_n(rst_n), .strobe(b_stb), .din(b_in),
    .held(b_held), .fire(b_fire)
  );

  xcvr_route #(.WIDTH(WIDTH)) u_route (
    .mode(mode), .sel_a2b(sel_a2b), .sel_b2a(sel_b2a),
    .a_live(a_in), .b_live(b_in), .a_held(a_held), .b_held(b_held),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  assert_isolate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));

  assert_drive_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && dir) |-> (b_oe && !a_oe));

  assert_drive_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && !dir) |-> (a_oe && !b_oe));

  assert_live_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (b_oe && !sel_a2b) |-> b_out == a_in);

  assert_stored_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (b_oe && sel_a2b) |-> b_out == a_held);

  assert_live_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_oe && !sel_b2a) |-> a_out == b_in);

  assert_stored_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (a_oe && sel_b2a) |-> a_out == b_held);

  // R3: capture on B side proceeds regardless of drive mode.
  assert_capture_any_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    b_fire |=> b_held == $past(b_in));

endmodule

// File: tb/bus_xcvr_reg_test.sv
module bus_xcvr_reg_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n, oe_n, dir, sel_a2b, sel_b2a, a_stb, b_stb;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         a_oe, b_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Bench's own view of the two registers.
  logic [W-1:0] mdl_a = '0;
  logic [W-1:0] mdl_b = '0;

  always #5 clk = ~clk;

  bus_xcvr_reg #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
    .sel_a2b(sel_a2b), .sel_b2a(sel_b2a), .a_stb(a_stb), .b_stb(b_stb),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic expect_val(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Full port check against the bench's mode table.
  task automatic check_ports(string req);
    logic eb, ea;
    logic [W-1:0] xb, xa;
    eb = !oe_n && dir;
    ea = !oe_n && !dir;
    xb = eb ? (sel_a2b ? mdl_a : a_in) : '0;
    xa = ea ? (sel_b2a ? mdl_b : b_in) : '0;
    expect_val({req, " b_oe"}, {7'd0, b_oe}, {7'd0, eb});
    expect_val({req, " a_oe"}, {7'd0, a_oe}, {7'd0, ea});
    expect_val({req, " b_out"}, b_out, xb);
    expect_val({req, " a_out"}, a_out, xa);
  endtask

  task automatic pulse_a(logic [W-1:0] v);
    @(negedge clk); a_in = v; a_stb = 1'b1;
    @(negedge clk); a_stb = 1'b0; mdl_a = v;
  endtask

  task automatic pulse_b(logic [W-1:0] v);
    @(negedge clk); b_in = v; b_stb = 1'b1;
    @(negedge clk); b_stb = 1'b0; mdl_b = v;
  endtask

  task automatic t_reset();
    @(negedge clk); oe_n = 0; dir = 1; sel_a2b = 1; #1;
    check_ports("R13 A reg zero after reset");
    dir = 0; sel_b2a = 1; #1;
    check_ports("R13 B reg zero after reset");
  endtask

  task automatic t_isolation_capture();
    for (int d = 0; d < 2; d++) begin
      @(negedge clk); oe_n = 1; dir = d[0]; sel_a2b = 1; sel_b2a = 1;
      pulse_a(8'h3C ^ d[7:0]);
      pulse_b(8'hA5 ^ d[7:0]);
      #1 check_ports("R4 isolation outputs");
    end
    @(negedge clk); oe_n = 0; dir = 1; sel_a2b = 1; #1;
    expect_val("R1 R3 A capture in isolation", b_out, 8'h3D);
    check_ports("R8 stored A to B");
    dir = 0; sel_b2a = 1; #1;
    expect_val("R2 R3 B capture in isolation", a_out, 8'hA4);
    check_ports("R10 stored B to A");
  endtask

  task automatic t_live();
    logic [W-1:0] pats [4] = '{8'h00, 8'hFF, 8'h5A, 8'h81};
    @(negedge clk); oe_n = 0; dir = 1; sel_a2b = 0;
    foreach (pats[i]) begin
      a_in = pats[i]; #1;
      expect_val("R7 live A to B", b_out, pats[i]);
      check_ports("R5 B drives");
    end
    dir = 0; sel_b2a = 0;
    foreach (pats[i]) begin
      b_in = ~pats[i]; #1;
      expect_val("R9 live B to A", a_out, ~pats[i]);
      check_ports("R6 A drives");
    end
  endtask

  task automatic t_capture_forward();
    @(negedge clk); oe_n = 0; dir = 1; sel_a2b = 1;
    a_in = 8'h77; a_stb = 1; #1;
    expect_val("R11 B before edge", b_out, mdl_a);
    @(posedge clk); #1;
    expect_val("R11 B after edge", b_out, 8'h77);
    @(negedge clk); a_stb = 0; mdl_a = 8'h77;
    dir = 0; sel_b2a = 1;
    b_in = 8'hE1; b_stb = 1; #1;
    expect_val("R11 A before edge", a_out, mdl_b);
    @(posedge clk); #1;
    expect_val("R11 A after edge", a_out, 8'hE1);
    @(negedge clk); b_stb = 0; mdl_b = 8'hE1;
  endtask

  task automatic t_held_strobe();
    @(negedge clk); oe_n = 0; dir = 1; sel_a2b = 1;
    a_in = 8'h11; a_stb = 1;
    @(negedge clk); mdl_a = 8'h11;
    for (int i = 0; i < 3; i++) begin
      a_in = 8'h22 + i[7:0];
      @(negedge clk); #1;
      expect_val("R14 held strobe no recapture", b_out, 8'h11);
    end
    a_stb = 0;
    @(negedge clk);
    pulse_a(8'h44);
    #1 expect_val("R14 recapture after new edge", b_out, 8'h44);
  endtask

  task automatic t_unused_select();
    @(negedge clk); oe_n = 0; dir = 1; sel_a2b = 0; a_in = 8'h96;
    for (int s = 0; s < 2; s++) begin
      sel_b2a = s[0]; #1;
      expect_val("R12 B output ignores sel_b2a", b_out, 8'h96);
      check_ports("R12 B drives");
    end
    dir = 0; sel_b2a = 1;
    for (int s = 0; s < 2; s++) begin
      sel_a2b = s[0]; #1;
      expect_val("R12 A output ignores sel_a2b", a_out, mdl_b);
      check_ports("R12 A drives");
    end
  endtask

  task automatic t_midrun_reset();
    @(negedge clk); oe_n = 0; dir = 1; sel_a2b = 1;
    #2 rst_n = 0; #1;
    mdl_a = '0; mdl_b = '0;
    expect_val("R13 async clear A", b_out, 8'h00);
    dir = 0; sel_b2a = 1; #1;
    expect_val("R13 async clear B", a_out, 8'h00);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    rst_n = 0; oe_n = 1; dir = 0; sel_a2b = 0; sel_b2a = 0;
    a_stb = 0; b_stb = 0; a_in = '0; b_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_isolation_capture();
    t_live();
    t_capture_forward();
    t_held_strobe();
    t_unused_select();
    t_midrun_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule